// File: doc/BRIEF.md
# Receive Ring Buffer Writer

This block takes received Ethernet frames one byte per cycle and stores them in a circular buffer in host memory. Each stored frame becomes a record: a 32-bit little-endian header, then the frame bytes. The header holds the frame length, which includes the CRC, and a status half-word. The status half-word carries the error flags and the address class of the frame. Framing and CRC checking happen upstream, so the error flags and the class arrive here as inputs.

Every record starts on a 4-byte boundary. Frame data that runs past the end of the ring continues from offset 0. The host reads records and reports how far it has read by writing a read-pointer register. The value it writes is its read position minus 16. The block compares this position with its own write offset to report an empty buffer and to decide whether a new record fits. Frames that do not fit are dropped and flagged as overflow. Two sticky interrupt bits report good receptions and overflows, and the host clears them with a write-one-to-clear access.

Top module: `rxring_writer`

## Requirements
- R1: The ring holds 2^BASE_LOG2 << `cfg_ring_idx` bytes. An index of 3 gives the same size as 2. Every memory offset is taken modulo the ring size, so the data of a record may wrap to offset 0 in the middle of a frame.
- R2: For each stored frame, one 32-bit word write (`mem_word`=1) goes to the record start. Bits 31:16 of that word hold the number of frame bytes received, CRC included.
- R3: Header bits 15:0 are the status. Bit 0 is OK, set when all `in_err` bits are zero. Bits 5:1 copy `in_err[4:0]` in this order: alignment, CRC, too long, runt, bad symbol. Bit 13 marks broadcast, bit 15 marks multicast that is not broadcast, and bit 14 marks a unicast frame for the station's own address. All other status bits are zero.
- R4: Frame byte i is written as a byte write (`mem_word`=0, data in `mem_wdata[7:0]`) at offset (start + 4 + i) modulo the ring size.
- R5: After a frame is stored, `wr_ofs` becomes (start + length + 4 + 3) with the two low bits cleared, modulo the ring size.
- R6: The read position is (`rdptr_wdata` + 16) modulo the ring size. `buf_empty` is 1 exactly when the read position equals `wr_ofs`. The register resets to 0xFFF0, so the reset read position is 0.
- R7: `cfg_accept` gates frames by class. Bit 3 admits broadcast, bit 2 admits multicast, bit 1 or bit 0 admits own-address unicast, and bit 0 admits any other unicast. Class priority is broadcast, then multicast, then own-address. A rejected frame writes nothing and changes neither `wr_ofs` nor `int_stat`.
- R8: A frame is stored only if its aligned record size (length + 4, rounded up to a multiple of 4) is strictly less than the free space. Free space is the read position minus the write offset modulo the ring size, or the whole ring when the two are equal. Otherwise the frame is dropped: no header is written, `wr_ofs` stays unchanged, `int_stat[4]` is set, and no byte is ever written into unread data.
- R9: `int_stat[0]` is set when a stored frame has status OK. Frames with errors are stored but do not set it.
- R10: Writing `irq_clr_data` with `irq_clr_we` clears the `int_stat` bits that are 1 in the data. If a clear and a set hit the same bit in the same cycle, the set wins. Bits other than 0 and 4 stay zero.
- R11: In the cycle after the last byte of a frame is accepted, `in_ready` is 0. The header write appears on the memory outputs one cycle after the last data byte write.
- R12: After reset, `wr_ofs` is 0, `buf_empty` is 1, `int_stat` is 0, `in_ready` is 1 and `mem_we` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_accept | input | 4 | Class acceptance mask |
| cfg_ring_idx | input | 2 | Ring size selector |
| in_valid | input | 1 | Frame byte valid |
| in_ready | output | 1 | Byte can be accepted |
| in_byte | input | 8 | Frame byte |
| in_sof | input | 1 | First byte of frame |
| in_eof | input | 1 | Last byte of frame |
| in_bcast | input | 1 | Frame is broadcast (sampled with sof) |
| in_mcast | input | 1 | Frame is multicast (sampled with sof) |
| in_own | input | 1 | Destination is station address (sampled with sof) |
| in_err | input | 5 | Error flags (sampled with eof) |
| rdptr_we | input | 1 | Host read-pointer write |
| rdptr_wdata | input | 16 | Host read position minus 16 |
| irq_clr_we | input | 1 | Interrupt clear strobe |
| irq_clr_data | input | 16 | Bits to clear |
| mem_we | output | 1 | Memory write strobe |
| mem_word | output | 1 | 1: 32-bit header write, 0: byte write |
| mem_addr | output | 16 | Byte offset in the ring |
| mem_wdata | output | 32 | Write data |
| wr_ofs | output | 16 | Start of the next record |
| buf_empty | output | 1 | Read position equals write offset |
| int_stat | output | 16 | Interrupt status (bit 0 good frame, bit 4 overflow) |

## Verification
Two events can fall in the same cycle: a frame commit that sets an interrupt bit, and a host clear aimed at that bit. The bench provokes this by issuing the clear in the header cycle that follows the last byte of a frame, after an earlier overflow has already set bit 4. The expected result is that bit 0 survives and bit 4 is cleared. A host read-pointer update that lands in the middle of a record is judged separately. A bench monitor checks that no byte write ever lands in the unread span between the read position and the write offset.

// File: rtl/rxring_pkg.sv
package rxring_pkg;

  typedef logic [15:0] ofs_t;

  typedef enum logic {ST_RX, ST_HDR} wr_state_e;

  typedef struct packed {
    logic       mcast;
    logic       own;
    logic       bcast;
    logic [6:0] rsv;
    logic       bad_sym;
    logic       runt;
    logic       too_long;
    logic       crc_bad;
    logic       align_bad;
    logic       ok;
  } rx_stat_t;

  // ring size in bytes; selector 3 behaves like 2
  function automatic ofs_t ring_size(input int base_log2, input logic [1:0] idx);
    int e;
    e = (idx == 2'd3) ? 2 : int'(idx);
    return ofs_t'(1) << (base_log2 + e);
  endfunction

  // aligned record footprint: header + frame, rounded up to 4
  function automatic ofs_t rec_span(input logic [15:0] len);
    return (len + 16'd7) & ~16'd3;
  endfunction

  // free bytes between write offset and read position
  function automatic ofs_t ring_gap(input ofs_t rd, input ofs_t wr, input ofs_t size);
    ofs_t d;
    d = (rd - wr) & (size - 16'd1);
    return (d == 16'd0) ? size : d;
  endfunction

endpackage

// File: rtl/rxring_filter.sv
module rxring_filter (
  input  logic [3:0] accept_mask,
  input  logic       bcast,
  input  logic       mcast,
  input  logic       own,
  output logic       accept,
  output logic       cls_bcast,
  output logic       cls_mcast,
  output logic       cls_own
);
  always_comb begin
    cls_bcast = bcast;
    cls_mcast = mcast & ~bcast;
    cls_own   = own & ~bcast & ~mcast;
    if (cls_bcast)      accept = accept_mask[3];
    else if (cls_mcast) accept = accept_mask[2];
    else if (cls_own)   accept = accept_mask[1] | accept_mask[0];
    else                accept = accept_mask[0];
  end
endmodule

// File: rtl/rxring_rdptr.sv
module rxring_rdptr
  import rxring_pkg::*;
#(
  parameter int BASE_LOG2 = 13,
  parameter logic [15:0] RD_RESET = 16'hFFF0,
  parameter int RD_BIAS = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rd_we,
  input  logic [15:0] rd_wdata,
  input  logic [1:0]  ring_idx,
  input  ofs_t        wr_ofs,
  output ofs_t        size,
  output ofs_t        free_bytes,
  output logic        empty
);
  logic [15:0] rd_reg;
  ofs_t        rd_pos;

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_reg <= RD_RESET;
    else if (rd_we) rd_reg <= rd_wdata;
  end

  always_comb begin
    size       = ring_size(BASE_LOG2, ring_idx);
    rd_pos     = (rd_reg + 16'(RD_BIAS)) & (size - 16'd1);
    free_bytes = ring_gap(rd_pos, wr_ofs, size);
    empty      = (rd_pos == wr_ofs);
  end
endmodule

// File: rtl/rxring_irq.sv
module rxring_irq #(
  parameter int NB = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] set_vec,
  input  logic          clr_we,
  input  logic [NB-1:0] clr_data,
  output logic [NB-1:0] status
);
  logic [NB-1:0] clr_vec;
  assign clr_vec = clr_we ? clr_data : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) status <= '0;
    else        status <= (status & ~clr_vec) | set_vec;
  end
endmodule

// File: rtl/rxring_writer.sv
module rxring_writer
  import rxring_pkg::*;
#(
  parameter int BASE_LOG2 = 13,
  parameter int IRQ_OK_BIT = 0,
  parameter int IRQ_OVF_BIT = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  cfg_accept,
  input  logic [1:0]  cfg_ring_idx,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_byte,
  input  logic        in_sof,
  input  logic        in_eof,
  input  logic        in_bcast,
  input  logic        in_mcast,
  input  logic        in_own,
  input  logic [4:0]  in_err,
  input  logic        rdptr_we,
  input  logic [15:0] rdptr_wdata,
  input  logic        irq_clr_we,
  input  logic [15:0] irq_clr_data,
  output logic        mem_we,
  output logic        mem_word,
  output logic [15:0] mem_addr,
  output logic [31:0] mem_wdata,
  output logic [15:0] wr_ofs,
  output logic        buf_empty,
  output logic [15:0] int_stat
);
  localparam int HDR_BYTES = 4;

  wr_state_e   state;
  ofs_t        wp, size, free_bytes;
  logic [15:0] cnt, cur_cnt;
  ofs_t        pos, byte_addr, span;
  logic        acc_q, bc_q, mc_q, own_q, ovf_q;
  logic [4:0]  err_q;
  logic        f_acc, f_bc, f_mc, f_own;
  logic        fire, acc_now, byte_room, fits;
  rx_stat_t    stat;
  logic [31:0] hdr_word;
  logic [15:0] irq_set;

  // named events, observed by the checker
  logic        byte_ev, commit_ev, drop_ev;

  rxring_filter u_filter (
    .accept_mask (cfg_accept),
    .bcast       (in_bcast),
    .mcast       (in_mcast),
    .own         (in_own),
    .accept      (f_acc),
    .cls_bcast   (f_bc),
    .cls_mcast   (f_mc),
    .cls_own     (f_own)
  );

  rxring_rdptr #(.BASE_LOG2(BASE_LOG2)) u_rdptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_we      (rdptr_we),
    .rd_wdata   (rdptr_wdata),
    .ring_idx   (cfg_ring_idx),
    .wr_ofs     (wp),
    .size       (size),
    .free_bytes (free_bytes),
    .empty      (buf_empty)
  );

  always_comb begin
    irq_set = '0;
    irq_set[IRQ_OK_BIT]  = commit_ev & stat.ok;
    irq_set[IRQ_OVF_BIT] = drop_ev;
  end

  rxring_irq #(.NB(16)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_vec  (irq_set),
    .clr_we   (irq_clr_we),
    .clr_data (irq_clr_data),
    .status   (int_stat)
  );

  assign in_ready = (state == ST_RX);
  assign fire     = in_valid & in_ready;

  always_comb begin
    cur_cnt   = in_sof ? 16'd0 : cnt;
    pos       = cur_cnt + 16'(HDR_BYTES);
    byte_room = pos < free_bytes;
    acc_now   = in_sof ? f_acc : acc_q;
    byte_ev   = fire & acc_now & byte_room;
    byte_addr = (wp + pos) & (size - 16'd1);
    span      = rec_span(cnt);
    fits      = ~ovf_q & (span < free_bytes);
    commit_ev = (state == ST_HDR) & acc_q & fits;
    drop_ev   = (state == ST_HDR) & acc_q & ~fits;

    stat           = '0;
    stat.ok        = ~|err_q;
    stat.align_bad = err_q[0];
    stat.crc_bad   = err_q[1];
    stat.too_long  = err_q[2];
    stat.runt      = err_q[3];
    stat.bad_sym   = err_q[4];
    stat.bcast     = bc_q;
    stat.mcast     = mc_q;
    stat.own       = own_q;
    hdr_word       = {cnt, stat};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_RX;
      wp    <= '0;
      cnt   <= '0;
      acc_q <= 1'b0;
      bc_q  <= 1'b0;
      mc_q  <= 1'b0;
      own_q <= 1'b0;
      ovf_q <= 1'b0;
      err_q <= '0;
    end else begin
      if (fire) begin
        cnt   <= cur_cnt + 16'd1;
        acc_q <= acc_now;
        ovf_q <= (in_sof ? 1'b0 : ovf_q) | (acc_now & ~byte_room);
        if (in_sof) begin
          bc_q  <= f_bc;
          mc_q  <= f_mc;
          own_q <= f_own;
        end
        if (in_eof) begin
          err_q <= in_err;
          state <= ST_HDR;
        end
      end
      if (state == ST_HDR) state <= ST_RX;
      if (commit_ev) wp <= (wp + span) & (size - 16'd1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_we    <= 1'b0;
      mem_word  <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we    <= byte_ev | commit_ev;
      mem_word  <= commit_ev;
      mem_addr  <= commit_ev ? wp : byte_addr;
      mem_wdata <= commit_ev ? hdr_word : {24'd0, in_byte};
    end
  end

  assign wr_ofs = wp;

endmodule

// File: rtl/rxring_writer_chk.sv
module rxring_writer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        in_eof,
  input logic        mem_we,
  input logic        mem_word,
  input logic [15:0] mem_addr,
  input logic [15:0] wr_ofs,
  input logic [15:0] int_stat,
  input logic        commit_ev,
  input logic        drop_ev
);
  AST_HDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we && mem_word |-> mem_addr[1:0] == 2'b00);                      // R5
  AST_HDR_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we && mem_word |-> mem_addr == $past(wr_ofs));                   // R2
  AST_COMMIT_WRITES_HDR: assert property (@(posedge clk) disable iff (!rst_n)
    commit_ev |=> mem_we && mem_word);                                   // R11
  AST_READY_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_eof |=> !in_ready);                       // R11
  AST_DROP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    drop_ev |=> $stable(wr_ofs) && int_stat[4]);                         // R8
  AST_OK_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_stat[0]) |-> $past(commit_ev));                            // R9
  AST_SPARE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (int_stat & 16'hFFEE) == 16'h0000);                                  // R10
endmodule

bind rxring_writer rxring_writer_chk u_chk (.*);

// File: tb/rxring_writer_tb.sv
module rxring_writer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BL = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cfg_accept = 4'hF;
  logic [1:0]  cfg_ring_idx = 2'd0;
  logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic        in_bcast = 1'b0, in_mcast = 1'b0, in_own = 1'b0;
  logic [7:0]  in_byte = '0;
  logic [4:0]  in_err = '0;
  logic        rdptr_we = 1'b0, irq_clr_we = 1'b0;
  logic [15:0] rdptr_wdata = '0, irq_clr_data = '0;
  logic        in_ready, mem_we, mem_word, buf_empty;
  logic [15:0] mem_addr, wr_ofs, int_stat;
  logic [31:0] mem_wdata;

  int checks = 0, errors = 0;
  int wp_m = 0, rp_m = 0, nsz = 64, viol = 0;
  logic [15:0] int_m = '0;
  logic [7:0]  dut_mem [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  rxring_writer #(.BASE_LOG2(BL)) u_dut (.*);

  // capture memory writes; flag any byte landing in unread data
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      if (mem_word) begin
        for (int k = 0; k < 4; k++) dut_mem[(int'(mem_addr) + k) % 256] = mem_wdata[8*k +: 8];
      end else begin
        dut_mem[int'(mem_addr) % 256] = mem_wdata[7:0];
        if (((int'(mem_addr) - rp_m + nsz) % nsz) < ((wp_m - rp_m + nsz) % nsz)) viol++;
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit admit(input logic [3:0] m, input int cls);
    case (cls)
      0: return m[3];
      1: return m[2];
      2: return m[1] | m[0];
      default: return m[0];
    endcase
  endfunction

  task automatic do_reset(input int idx);
    cfg_ring_idx = 2'(idx);
    nsz = 1 << (BL + (idx > 2 ? 2 : idx));
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    wp_m = 0; rp_m = 0; int_m = '0;
    @(negedge clk);
  endtask

  task automatic host_rd(input int p);
    @(negedge clk); rdptr_we = 1'b1; rdptr_wdata = 16'(p - 16);
    @(negedge clk); rdptr_we = 1'b0;
    rp_m = p;
    chk(buf_empty == (rp_m == wp_m), "R6", "buf_empty", buf_empty, rp_m == wp_m);
  endtask

  task automatic irq_clear(input logic [15:0] m);
    @(negedge clk); irq_clr_we = 1'b1; irq_clr_data = m;
    @(negedge clk); irq_clr_we = 1'b0;
    int_m = int_m & ~m;
    chk(int_stat == int_m, "R10", "int_stat after clear", int_stat, int_m);
  endtask

  // cls: 0 broadcast, 1 multicast, 2 own unicast, 3 other unicast
  task automatic send_frame(input int len, input int cls, input logic [4:0] err,
                            input logic [7:0] seed, input bit clr_hdr);
    bit acc, fits;
    int gap, span, wp_old, bad;
    logic [15:0] st;
    logic [31:0] hdr_exp, hdr_act;
    acc    = admit(cfg_accept, cls);
    gap    = (rp_m - wp_m + nsz) % nsz;
    if (gap == 0) gap = nsz;
    span   = (len + 4 + 3) & ~3;
    fits   = span < gap;
    wp_old = wp_m;
    viol   = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sof = (i == 0); in_eof = (i == len - 1);
      in_byte  = 8'(int'(seed) + i * 7);
      in_bcast = (cls == 0); in_mcast = (cls == 1); in_own = (cls == 2);
      in_err   = (i == len - 1) ? err : 5'd0;
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    chk(in_ready == 1'b0, "R11", "ready in header cycle", in_ready, 0);
    if (clr_hdr) begin irq_clr_we = 1'b1; irq_clr_data = 16'h0011; end
    @(negedge clk);
    irq_clr_we = 1'b0;
    if (acc && fits)
      chk(mem_we && mem_word && mem_addr == 16'(wp_old), "R11", "header write timing", {mem_we, mem_word, mem_addr}, {2'b11, 16'(wp_old)});
    @(negedge clk);
    if (clr_hdr) int_m = int_m & ~16'h0011;
    if (acc) begin
      if (fits) begin
        wp_m = (wp_m + span) % nsz;
        if (err == 0) int_m = int_m | 16'h0001;
      end else int_m = int_m | 16'h0010;
    end
    chk(wr_ofs == 16'(wp_m), !acc ? "R7" : (fits ? "R5" : "R8"), "wr_ofs", wr_ofs, wp_m);
    chk(int'(wr_ofs) < nsz, "R1", "wr_ofs inside ring", wr_ofs, nsz);
    chk(int_stat == int_m, acc && !fits ? "R8" : "R9", "int_stat", int_stat, int_m);
    chk(viol == 0, "R8", "bytes written into unread data", viol, 0);
    if (acc && fits) begin
      st = {15'd0, err == 0} | (16'(err) << 1);
      if (cls == 0) st[13] = 1'b1;
      if (cls == 1) st[15] = 1'b1;
      if (cls == 2) st[14] = 1'b1;
      hdr_exp = {16'(len), st};
      for (int k = 0; k < 4; k++) hdr_act[8*k +: 8] = dut_mem[wp_old + k];
      chk(hdr_act[31:16] == hdr_exp[31:16], "R2", "header length", hdr_act[31:16], hdr_exp[31:16]);
      chk(hdr_act[15:0] == hdr_exp[15:0], "R3", "header status", hdr_act[15:0], hdr_exp[15:0]);
      bad = 0;
      for (int i = 0; i < len; i++)   // R1 wrap modulo ring size
        if (dut_mem[(wp_old + 4 + i) % nsz] != 8'(int'(seed) + i * 7)) bad++;
      chk(bad == 0, "R4", "data byte mismatches", bad, 0);
    end
  endtask

  initial begin
    for (int a = 0; a < 256; a++) dut_mem[a] = '0;
    do_reset(0);
    // R12 reset state
    chk(wr_ofs == 16'd0, "R12", "wr_ofs", wr_ofs, 0);
    chk(buf_empty == 1'b1, "R12", "buf_empty", buf_empty, 1);
    chk(int_stat == 16'd0, "R12", "int_stat", int_stat, 0);
    chk(in_ready == 1'b1 && mem_we == 1'b0, "R12", "ready/mem_we", {in_ready, mem_we}, 2'b10);

    // size sweep with wrap, alignment, errors and overflow
    for (int idx = 0; idx < 4; idx++) begin
      cfg_accept = 4'hF;
      do_reset(idx);
      for (int len = 1; len <= nsz / 2 + 6; len += 3) begin
        send_frame(len, len % 4, (len % 4 == 3) ? 5'(1 << (len % 5)) : 5'd0, 8'(len * 13), 1'b0);
        if (len % 8 < 5) host_rd(wp_m);
        irq_clear(16'h0011);
      end
    end

    // acceptance filter over every mask and class
    do_reset(0);
    for (int m = 0; m < 16; m++) begin
      for (int c = 0; c < 4; c++) begin
        cfg_accept = 4'(m);
        send_frame(8, c, 5'd0, 8'(m * 16 + c), 1'b0);   // R7
        host_rd(wp_m);
        if (int_m != 0) irq_clear(16'h0011);
      end
    end

    // set and clear collide in the header cycle (R10)
    cfg_accept = 4'hF;
    do_reset(0);
    send_frame(40, 3, 5'd0, 8'h21, 1'b0);
    send_frame(40, 3, 5'd0, 8'h42, 1'b0);   // dropped: overflow
    send_frame(8, 2, 5'd0, 8'h63, 1'b1);    // commit while host clears
    chk(int_stat == 16'h0001, "R10", "set wins over clear", int_stat, 16'h0001);
    irq_clear(16'h0001);
    host_rd(wp_m);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule